// File: doc/BRIEF.md
# Streaming Pixel Format Converter with Box Downscale

This block sits in a display or blit datapath and converts a stream of packed pixels from one colour layout to another. Each accepted input word holds one source pixel, little-endian, in one of five packed layouts. The pixel is widened to an internal form with four 8-bit channels (red, green, blue, alpha). It can optionally be averaged with its neighbours in stream order, and is then packed again into the selected destination layout.

Configuration is static while a stream runs. It covers the source layout, the destination layout, the averaging mode and a raw flag. The raw flag turns the block into a plain word forwarder. Both stream edges use a valid/ready handshake. One output register decouples the two sides. A new group can be accepted in the same cycle that the previous result is taken.

Top module: `pixel_fmt_conv`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0, and `in_ready` is 1 once reset is applied.
- R2: Decode uses the following codes and word layouts. Code 0 is 32-bit {R[31:24],G[23:16],B[15:8],A[7:0]}. Code 1 is 24-bit {R[23:16],G[15:8],B[7:0]}, with alpha read as 255. Code 2 is 5-6-5 {R[15:11],G[10:5],B[4:0]}, with alpha read as 255. Code 3 is 5-5-5-1 {R[15:11],G[10:6],B[5:1],A[0]}. Code 4 is 4-4-4-4 {R[15:12],G[11:8],B[7:4],A[3:0]}. A channel narrower than 8 bits is widened by copying its top bits into the vacated low bits, and a 1-bit alpha becomes 0 or 255.
- R3: Encode uses the same codes and layouts. Each channel is truncated to its most significant bits. Bits of `out_data` above the pixel width are 0.
- R4: Averaging mode 0 (or 3) gives exactly one output pixel, one cycle after each accepted input pixel.
- R5: Averaging mode 1 gives one output per two accepted pixels. Each channel is the sum of the pair divided by two, truncated.
- R6: Averaging mode 2 gives one output per four accepted pixels. Each channel is the sum of the four divided by four, truncated. No output appears before the last pixel of a group is accepted.
- R7: With `cfg_raw` high, each accepted `in_data` word is presented unchanged on `out_data` one cycle later, regardless of layouts or averaging mode.
- R8: A source layout code of 5, 6 or 7 decodes to all channels zero.
- R9: A destination layout code of 5, 6 or 7 (without raw) accepts the input but produces no output.
- R10: While `out_valid` is high and `out_ready` is low, `out_data` holds its value and `in_ready` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_in_fmt | input | 3 | Source layout code |
| cfg_out_fmt | input | 3 | Destination layout code |
| cfg_scale | input | 2 | Averaging mode: 0 none, 1 pairs, 2 quads, 3 none |
| cfg_raw | input | 1 | Forward words without conversion |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Input pixel can be taken |
| in_data | input | 32 | Input pixel word, little-endian |
| out_valid | output | 1 | Output pixel present |
| out_ready | input | 1 | Output pixel taken |
| out_data | output | 32 | Output pixel word |

## Verification
The bench targets several corner cases. Narrow channels must expand by replication: a design that pads with zeros returns 0x80 instead of 0x84 for a 5-bit 16. The quad average must truncate: a rounding design gives 0xFF instead of 0xFE in the red channel. Partial groups must emit nothing, which catches a design that shows intermediate sums. An unknown destination must drop the pixel rather than emit a zero word. Under backpressure the output must stay held: a design that lets `in_ready` rise would overwrite the stalled word. A correct design must also let the held word and the next input exchange in one cycle.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
  localparam int CH_W  = 8;
  localparam int NCH   = 4;
  localparam int PIX_W = CH_W * NCH;
  localparam int SUM_W = CH_W + 2;

  localparam logic [2:0] FMT_RGBA8  = 3'd0;
  localparam logic [2:0] FMT_RGB8   = 3'd1;
  localparam logic [2:0] FMT_RGB565 = 3'd2;
  localparam logic [2:0] FMT_RGB5A1 = 3'd3;
  localparam logic [2:0] FMT_RGBA4  = 3'd4;

  localparam logic [1:0] SCL_NONE = 2'd0;
  localparam logic [1:0] SCL_PAIR = 2'd1;
  localparam logic [1:0] SCL_QUAD = 2'd2;

  typedef struct packed {
    logic [CH_W-1:0] r;
    logic [CH_W-1:0] g;
    logic [CH_W-1:0] b;
    logic [CH_W-1:0] a;
  } chan4_t;
endpackage

// File: rtl/pfc_decode.sv
module pfc_decode
  import pfc_pkg::*;
(
  input  logic [PIX_W-1:0] word,
  input  logic [2:0]       fmt,
  output chan4_t           px
);
  always_comb begin
    px = '0;
    case (fmt)
      FMT_RGBA8:  px = chan4_t'(word);
      FMT_RGB8:   px = '{r: word[23:16], g: word[15:8], b: word[7:0], a: 8'hFF};
      FMT_RGB565: px = '{r: {word[15:11], word[15:13]},
                         g: {word[10:5],  word[10:9]},
                         b: {word[4:0],   word[4:2]},
                         a: 8'hFF};
      FMT_RGB5A1: px = '{r: {word[15:11], word[15:13]},
                         g: {word[10:6],  word[10:8]},
                         b: {word[5:1],   word[5:3]},
                         a: {8{word[0]}}};
      FMT_RGBA4:  px = '{r: {2{word[15:12]}}, g: {2{word[11:8]}},
                         b: {2{word[7:4]}},   a: {2{word[3:0]}}};
      default:    px = '0;
    endcase
  end
endmodule

// File: rtl/pfc_average.sv
module pfc_average
  import pfc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       take,
  input  logic [1:0] scale,
  input  chan4_t     px,
  output logic       last,
  output chan4_t     avg
);
  logic [1:0] shift;
  logic [1:0] grp_max;
  logic [1:0] cnt_q, cnt_d;
  logic [PIX_W-1:0] px_flat, avg_flat;
  logic [NCH-1:0][SUM_W-1:0] sum_q, sum_d, sum_now;

  always_comb begin
    case (scale)
      SCL_PAIR: shift = 2'd1;
      SCL_QUAD: shift = 2'd2;
      default:  shift = 2'd0;
    endcase
    grp_max = 2'((3'd1 << shift) - 3'd1);
    last    = (cnt_q == grp_max);
  end

  assign px_flat = px;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign sum_now[c] = sum_q[c] + {2'b00, px_flat[c*CH_W +: CH_W]};
    assign avg_flat[c*CH_W +: CH_W] = CH_W'(sum_now[c] >> shift);
    always_comb begin
      sum_d[c] = sum_q[c];
      if (take) sum_d[c] = last ? '0 : sum_now[c];
    end
  end

  assign avg = chan4_t'(avg_flat);

  always_comb begin
    cnt_d = cnt_q;
    if (take) cnt_d = last ? 2'd0 : cnt_q + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sum_q <= '0;
    end else if (take) begin
      cnt_q <= cnt_d;
      sum_q <= sum_d;
    end
  end

  // R6: the group counter never passes the group size
  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= grp_max);
  // R4: without averaging no partial sum is ever held
  a_r4_no_partial: assert property (@(posedge clk) disable iff (!rst_n)
    (shift == 2'd0) |-> (cnt_q == 2'd0));
endmodule

// File: rtl/pfc_encode.sv
module pfc_encode
  import pfc_pkg::*;
(
  input  chan4_t           px,
  input  logic [2:0]       fmt,
  output logic [PIX_W-1:0] word,
  output logic             known
);
  always_comb begin
    known = 1'b1;
    word  = '0;
    case (fmt)
      FMT_RGBA8:  word = px;
      FMT_RGB8:   word = {8'h00, px.r, px.g, px.b};
      FMT_RGB565: word = {16'h0000, px.r[7:3], px.g[7:2], px.b[7:3]};
      FMT_RGB5A1: word = {16'h0000, px.r[7:3], px.g[7:3], px.b[7:3], px.a[7]};
      FMT_RGBA4:  word = {16'h0000, px.r[7:4], px.g[7:4], px.b[7:4], px.a[7:4]};
      default: begin
        known = 1'b0;
        word  = '0;
      end
    endcase
  end
endmodule

// File: rtl/pixel_fmt_conv.sv
module pixel_fmt_conv
  import pfc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       cfg_in_fmt,
  input  logic [2:0]       cfg_out_fmt,
  input  logic [1:0]       cfg_scale,
  input  logic             cfg_raw,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PIX_W-1:0] out_data
);
  chan4_t           dec_px, avg_px;
  logic             grp_last, enc_known, take, emit;
  logic [1:0]       scale_eff;
  logic [PIX_W-1:0] enc_word;
  logic             vld_q, vld_d;
  logic [PIX_W-1:0] dat_q, dat_d;

  assign scale_eff = cfg_raw ? SCL_NONE : cfg_scale;
  assign in_ready  = !vld_q || out_ready;
  assign take      = in_valid && in_ready;

  pfc_decode u_dec (.word(in_data), .fmt(cfg_in_fmt), .px(dec_px));

  pfc_average u_avg (
    .clk(clk), .rst_n(rst_n), .take(take), .scale(scale_eff),
    .px(dec_px), .last(grp_last), .avg(avg_px)
  );

  pfc_encode u_enc (.px(avg_px), .fmt(cfg_out_fmt), .word(enc_word), .known(enc_known));

  assign emit = take && grp_last && (cfg_raw || enc_known);

  always_comb begin
    vld_d = vld_q;
    dat_d = dat_q;
    if (emit) begin
      vld_d = 1'b1;
      dat_d = cfg_raw ? in_data : enc_word;
    end else if (out_ready) begin
      vld_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q <= '0;
    end else if (emit) begin
      dat_q <= dat_d;
    end
  end

  assign out_valid = vld_q;
  assign out_data  = dat_q;

  // R10: a stalled output stays put
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  // R7: raw words come through untouched
  a_r7_raw: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && cfg_raw) |=> (out_valid && out_data == $past(in_data)));
  // R9: unknown destination yields nothing
  a_r9_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !cfg_raw && cfg_out_fmt > 3'd4) |=> !out_valid);
  // R6: no output before a group completes
  a_r6_no_early: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !grp_last) |=> !out_valid);
  // R4: one output per pixel when not averaging
  a_r4_single: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !cfg_raw && cfg_scale == SCL_NONE && cfg_out_fmt <= 3'd4)
    |=> out_valid);
endmodule

// File: tb/test_pixel_fmt_conv.sv
module test_pixel_fmt_conv;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  cfg_in_fmt, cfg_out_fmt;
  logic [1:0]  cfg_scale;
  logic        cfg_raw;
  logic        in_valid, in_ready, out_valid, out_ready;
  logic [31:0] in_data, out_data;

  int checks = 0;
  int errors = 0;

  // {src code, dst code, input word, expected output word}
  localparam logic [69:0] VEC [NVEC] = '{
    {3'd0, 3'd0, 32'h12345678, 32'h12345678},
    {3'd2, 3'd0, 32'h0000F81F, 32'hFF00FFFF},
    {3'd2, 3'd0, 32'h00000841, 32'h080808FF},
    {3'd3, 3'd0, 32'h00008001, 32'h840000FF},
    {3'd3, 3'd0, 32'h00000000, 32'h00000000},
    {3'd4, 3'd0, 32'h00001234, 32'h11223344},
    {3'd1, 3'd0, 32'h00ABCDEF, 32'hABCDEFFF},
    {3'd0, 3'd2, 32'hFF804011, 32'h0000FC08},
    {3'd0, 3'd3, 32'h87654380, 32'h00008311},
    {3'd0, 3'd4, 32'h9ABCDEF0, 32'h00009BDF},
    {3'd0, 3'd1, 32'h11223344, 32'h00112233},
    {3'd5, 3'd0, 32'hFFFFFFFF, 32'h00000000}
  };

  pixel_fmt_conv i_pixel_fmt_conv (
    .clk(clk), .rst_n(rst_n),
    .cfg_in_fmt(cfg_in_fmt), .cfg_out_fmt(cfg_out_fmt),
    .cfg_scale(cfg_scale), .cfg_raw(cfg_raw),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] d);
    in_data  = d;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic string vec_req(input int i);
    if (i < 7) return "R2";
    if (i < 11) return "R3";
    return "R8";
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_in_fmt = 3'd0; cfg_out_fmt = 3'd0; cfg_scale = 2'd0;
    cfg_raw = 1'b0; in_valid = 1'b0; in_data = '0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 out_valid", {31'd0, out_valid}, 32'd0);
    chk("R1 in_ready", {31'd0, in_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);

    // vector table, no averaging (R4: each pixel gives one output)
    for (int i = 0; i < NVEC; i++) begin
      cfg_in_fmt  = VEC[i][69:67];
      cfg_out_fmt = VEC[i][66:64];
      push(VEC[i][63:32]);
      chk("R4 out_valid", {31'd0, out_valid}, 32'd1);
      chk(vec_req(i), out_data, VEC[i][31:0]);
    end

    // R6: quad average with truncation
    cfg_in_fmt = 3'd0; cfg_out_fmt = 3'd0; cfg_scale = 2'd2;
    push(32'hFF001080);
    chk("R6 partial1", {31'd0, out_valid}, 32'd0);
    push(32'hFF002080);
    chk("R6 partial2", {31'd0, out_valid}, 32'd0);
    push(32'hFF003080);
    chk("R6 partial3", {31'd0, out_valid}, 32'd0);
    push(32'hFE034080);
    chk("R6 valid", {31'd0, out_valid}, 32'd1);
    chk("R6 data", out_data, 32'hFE002880);

    // R5: pair average
    cfg_scale = 2'd1;
    push(32'h10203040);
    chk("R5 partial", {31'd0, out_valid}, 32'd0);
    push(32'h11213141);
    chk("R5 valid", {31'd0, out_valid}, 32'd1);
    chk("R5 data", out_data, 32'h10203040);

    // R7: raw forward ignores layouts and averaging
    cfg_scale = 2'd2; cfg_in_fmt = 3'd2; cfg_out_fmt = 3'd4; cfg_raw = 1'b1;
    push(32'hDEADBEEF);
    chk("R7 valid", {31'd0, out_valid}, 32'd1);
    chk("R7 data", out_data, 32'hDEADBEEF);
    cfg_raw = 1'b0; cfg_scale = 2'd0; cfg_in_fmt = 3'd0;
    @(negedge clk);

    // R9: unknown destination drops the pixel
    cfg_out_fmt = 3'd6;
    push(32'h01020304);
    chk("R9 no output", {31'd0, out_valid}, 32'd0);
    chk("R9 in_ready", {31'd0, in_ready}, 32'd1);
    cfg_out_fmt = 3'd0;
    push(32'hA1B2C3D4);
    chk("R9 recovers", out_data, 32'hA1B2C3D4);
    @(negedge clk);

    // R10: backpressure
    out_ready = 1'b0;
    push(32'h0BADF00D);
    chk("R10 valid", {31'd0, out_valid}, 32'd1);
    chk("R10 in_ready low", {31'd0, in_ready}, 32'd0);
    in_data = 32'hCAFEBABE; in_valid = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 held", out_data, 32'h0BADF00D);
    chk("R10 still stalled", {31'd0, in_ready}, 32'd0);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10 swap valid", {31'd0, out_valid}, 32'd1);
    chk("R10 swap data", out_data, 32'hCAFEBABE);
    @(negedge clk);
    chk("R10 drained", {31'd0, out_valid}, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule